// File: doc/BRIEF.md
# Parallel Pseudorandom Test-Word Generator

This block emits one pseudorandom test word on every enabled sample clock, of the kind a data converter places on its output bus while its link is being qualified. Two sequences are offered: a short one with a 9-stage register, repeating every 511 bits, and a long one with a 23-stage register. Within a single clock the selected register is stepped as many times as the converter has bits, and the bits it emits are packed MSB-first into a 16-bit word.

The word can be presented as offset binary or as two's complement, and a converter of fewer than 16 bits receives its word left-aligned, with zeros in the unused low bits. The output side follows stream rules. `out_valid` marks a fresh word. The consumer applies back-pressure through `en`: while `en` is low the generator does not advance, the last word stays on `out_data`, and `out_valid` is low. No word is ever skipped, so the stream resumes exactly where it stopped.

Top module: `prbs_tpg`

## Requirements
- R1: While `rst` is high at a clock edge, `out_data` becomes 0 and `out_valid` becomes 0, and both sequence registers are loaded with all ones.
- R2: With `mode_sel`=0 the short sequence is used. Its 9-stage register (stages 0..8) shifts left each step, and stage 4 XOR stage 8 enters at stage 0. The bit emitted is stage 8 before the shift. From the all-ones seed at 16 bits in offset binary, the first word is 0xFF83.
- R3: With `mode_sel`=1 the long sequence is used. Its 23-stage register steps the same way, with stage 17 XOR stage 22 (stages 18 and 23 counted from one) as feedback and stage 22 emitted. The first two 16-bit offset-binary words from the seed are 0xFFFF and 0xFE00.
- R4: Each enabled clock consumes exactly N register steps, where N is the effective resolution. The first emitted bit lands in bit 15 and later bits fill downward. Consecutive words continue the bit stream without gaps, so at N=16 short-sequence word k+511 equals word k.
- R5: With `fmt_sel`=1 (two's complement) the word equals the offset-binary word (`fmt_sel`=0) with bit 15 inverted.
- R6: For a resolution N from 8 to 16 the N bits occupy bits 15 down to 16-N, and bits 15-N down to 0 are zero. At N=8 the short sequence gives 0xFF00 and then 0x8300.
- R7: A `res_bits` value below 8 acts as 8, and a value above 16 acts as 16.
- R8: At a clock edge with `en` low, `out_data` holds, `out_valid` becomes 0 and no register advances. The next enabled word continues the sequence.
- R9: At a clock edge where `mode_sel` differs from its value at the previous edge, the newly selected register restarts from all ones. The first word produced in that mode, whether on this edge or later, is the start of its sequence.
- R10: `out_valid` at an edge equals `en` sampled at the previous edge, so the first word appears one clock after `en` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance and emit a word; low applies back-pressure |
| mode_sel | input | 1 | 0 = short 9-stage sequence, 1 = long 23-stage sequence |
| fmt_sel | input | 1 | 0 = offset binary, 1 = two's complement |
| res_bits | input | 5 | Converter resolution in bits, 8 to 16 |
| out_data | output | 16 | Registered test word, MSB-aligned |
| out_valid | output | 1 | A new word is on `out_data` |

## Verification
The main function is run at every resolution from 8 to 16, in both sequences and both formats. Against an arithmetic bit-serial model this separates step-count errors from bit-ordering and alignment errors. Known seed words, plus the 511-word repeat of the short sequence, pin down tap positions and packing independently of the model. Irregular enable patterns and mode switches, including a switch made while the generator is stalled, distinguish correct hold and restart behaviour from lost or duplicated bits, and out-of-range resolutions confirm the clamping.

// File: rtl/prbs_tpg_pkg.sv
package prbs_tpg_pkg;
  localparam int SHORT_LEN = 9;
  localparam int SHORT_TAP = 4;
  localparam int LONG_LEN  = 23;
  localparam int LONG_TAP  = 17;

  typedef enum logic {
    PAT_SHORT = 1'b0,
    PAT_LONG  = 1'b1
  } pat_e;

  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } fmt_e;

  function automatic int chan_len(input int idx);
    return (idx == 0) ? SHORT_LEN : LONG_LEN;
  endfunction

  function automatic int chan_tap(input int idx);
    return (idx == 0) ? SHORT_TAP : LONG_TAP;
  endfunction
endpackage

// File: rtl/prbs_lfsr_unroll.sv
// Combinational chain of STEPS Fibonacci shift steps starting at state_i.
// bits_o[STEPS-1] is the bit emitted by the first step.
module prbs_lfsr_unroll #(
  parameter int LEN   = 9,
  parameter int TAP   = 4,
  parameter int STEPS = 16
) (
  input  logic [LEN-1:0]             state_i,
  output logic [STEPS-1:0]           bits_o,
  output logic [STEPS:0][LEN-1:0]    chain_o
);
  assign chain_o[0] = state_i;

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    assign bits_o[STEPS-1-k] = chain_o[k][LEN-1];
    assign chain_o[k+1]      = {chain_o[k][LEN-2:0],
                                chain_o[k][TAP] ^ chain_o[k][LEN-1]};
  end
endmodule

// File: rtl/prbs_chan.sv
// One sequence register with its unrolled next-state logic.
module prbs_chan #(
  parameter int LEN    = 9,
  parameter int TAP    = 4,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              restart,
  input  logic [CNT_W-1:0]  nsteps,
  output logic [WORD_W-1:0] bits_o
);
  logic [LEN-1:0]              state_q;
  logic [LEN-1:0]              start;
  logic [WORD_W:0][LEN-1:0]    chain;

  assign start = restart ? {LEN{1'b1}} : state_q;

  prbs_lfsr_unroll #(
    .LEN   (LEN),
    .TAP   (TAP),
    .STEPS (WORD_W)
  ) u_unroll (
    .state_i (start),
    .bits_o  (bits_o),
    .chain_o (chain)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= {LEN{1'b1}};
    end else if (advance) begin
      state_q <= chain[nsteps];
    end else if (restart) begin
      state_q <= {LEN{1'b1}};
    end
  end
endmodule

// File: rtl/prbs_word_fmt.sv
// Keeps the top nsteps bits and applies the selected number format.
module prbs_word_fmt #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic [WORD_W-1:0] raw_i,
  input  logic [CNT_W-1:0]  nsteps,
  input  logic              twos_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] keep_mask;
  logic [WORD_W-1:0] sign_flip;

  assign keep_mask = ~({WORD_W{1'b1}} >> nsteps);
  assign sign_flip = {twos_i, {(WORD_W-1){1'b0}}};
  assign word_o    = (raw_i & keep_mask) ^ sign_flip;
endmodule

// File: rtl/prbs_tpg.sv
module prbs_tpg
  import prbs_tpg_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int RES_MIN = 8,
  parameter int RES_W   = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              mode_sel,
  input  logic              fmt_sel,
  input  logic [RES_W-1:0]  res_bits,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid
);
  localparam int NCHAN = 2;

  logic                          mode_q;
  logic                          mode_changed;
  logic [RES_W-1:0]              nsteps;
  logic [NCHAN-1:0][WORD_W-1:0]  chan_bits;
  logic [WORD_W-1:0]             word_next;
  pat_e                          pat_sel;
  fmt_e                          fmt;

  assign pat_sel      = pat_e'(mode_sel);
  assign fmt          = fmt_e'(fmt_sel);
  assign mode_changed = (mode_sel != mode_q);

  always_comb begin
    if (res_bits < RES_W'(RES_MIN)) begin
      nsteps = RES_W'(RES_MIN);
    end else if (res_bits > RES_W'(WORD_W)) begin
      nsteps = RES_W'(WORD_W);
    end else begin
      nsteps = res_bits;
    end
  end

  for (genvar g = 0; g < NCHAN; g++) begin : g_chan
    logic is_sel;
    assign is_sel = (pat_sel == pat_e'(g));

    prbs_chan #(
      .LEN    (chan_len(g)),
      .TAP    (chan_tap(g)),
      .WORD_W (WORD_W),
      .CNT_W  (RES_W)
    ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .advance (en && is_sel),
      .restart (mode_changed && is_sel),
      .nsteps  (nsteps),
      .bits_o  (chan_bits[g])
    );
  end

  prbs_word_fmt #(
    .WORD_W (WORD_W),
    .CNT_W  (RES_W)
  ) u_fmt (
    .raw_i  (chan_bits[pat_sel]),
    .nsteps (nsteps),
    .twos_i (fmt == FMT_TWOS),
    .word_o (word_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= mode_sel;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      mode_q    <= mode_sel;
      out_valid <= en;
      if (en) begin
        out_data <= word_next;
      end
    end
  end
endmodule

// File: rtl/prbs_tpg_chk.sv
module prbs_tpg_chk #(
  parameter int WORD_W  = 16,
  parameter int RES_MIN = 8,
  parameter int RES_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [RES_W-1:0]  res_bits,
  input logic [WORD_W-1:0] out_data,
  input logic              out_valid
);
  logic              rst_d;
  logic              en_d;
  logic [RES_W-1:0]  res_d;
  logic [WORD_W-1:0] data_d;

  always_ff @(posedge clk) begin
    rst_d  <= rst;
    en_d   <= en;
    res_d  <= res_bits;
    data_d <= out_data;
  end

  function automatic logic [WORD_W-1:0] low_mask(input logic [RES_W-1:0] r);
    int n;
    n = int'(r);
    if (n < RES_MIN) n = RES_MIN;
    if (n > WORD_W)  n = WORD_W;
    return {WORD_W{1'b1}} >> n;
  endfunction

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (!out_valid && out_data == '0)); // R1

  AST_VALID_LAGS_EN: assert property (@(posedge clk) disable iff (rst)
    !rst_d |-> (out_valid == en_d)); // R10

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (!rst_d && !en_d) |-> (out_data == data_d)); // R8

  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!rst_d && out_valid) |-> ((out_data & low_mask(res_d)) == '0)); // R6
endmodule

bind prbs_tpg prbs_tpg_chk #(
  .WORD_W  (WORD_W),
  .RES_MIN (RES_MIN),
  .RES_W   (RES_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .res_bits  (res_bits),
  .out_data  (out_data),
  .out_valid (out_valid)
);

// File: tb/prbs_tpg_bench.sv
module prbs_tpg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        mode_sel = 1'b0;
  logic        fmt_sel = 1'b0;
  logic [4:0]  res_bits = 5'd16;
  logic [15:0] out_data;
  logic        out_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [22:0] m_short, m_long;
  logic        m_mode;
  logic [15:0] e_data;
  logic        e_valid;

  always #10 clk = ~clk;

  prbs_tpg u_prbs_tpg (
    .clk(clk), .rst(rst), .en(en), .mode_sel(mode_sel),
    .fmt_sel(fmt_sel), .res_bits(res_bits),
    .out_data(out_data), .out_valid(out_valid)
  );

  // Bit-serial model: width w, feedback tap t, n steps, MSB-first packing.
  task automatic gen(inout logic [22:0] s, input int w, input int t,
                     input int n, output logic [15:0] word);
    logic fb;
    word = '0;
    for (int i = 0; i < n; i++) begin
      word[15-i] = s[w-1];
      fb = s[t] ^ s[w-1];
      s = ((s << 1) | 23'(fb)) & ((23'd1 << w) - 23'd1);
    end
  endtask

  task automatic model_edge();
    int n;
    logic [15:0] w;
    if (rst) begin
      m_short = 23'h1FF; m_long = 23'h7FFFFF; m_mode = mode_sel;
      e_data = '0; e_valid = 1'b0;
    end else begin
      if (mode_sel != m_mode) begin
        if (mode_sel) m_long = 23'h7FFFFF; else m_short = 23'h1FF;
      end
      m_mode = mode_sel;
      if (en) begin
        n = int'(res_bits);
        if (n < 8) n = 8;
        if (n > 16) n = 16;
        if (mode_sel) gen(m_long, 23, 17, n, w);
        else          gen(m_short, 9, 4, n, w);
        e_data = w ^ (fmt_sel ? 16'h8000 : 16'h0000);
        e_valid = 1'b1;
      end else begin
        e_valid = 1'b0;
      end
    end
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic check_model(input string tag);
    checks++;
    if (out_data !== e_data || out_valid !== e_valid) begin
      failures++;
      $display("FAIL %s: data=%h valid=%b expected data=%h valid=%b",
               tag, out_data, out_valid, e_data, e_valid);
    end
  endtask

  task automatic check_word(input string tag, input logic [15:0] exp);
    checks++;
    if (out_data !== exp || out_valid !== 1'b1) begin
      failures++;
      $display("FAIL %s: data=%h valid=%b expected data=%h valid=1",
               tag, out_data, out_valid, exp);
    end
  endtask

  task automatic run(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      tick();
      check_model(tag);
    end
  endtask

  task automatic do_reset(input logic m, input logic f, input logic [4:0] r);
    rst = 1'b1; en = 1'b0; mode_sel = m; fmt_sel = f; res_bits = r;
    tick(); tick();
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] first, held;
    #1;
    do_reset(1'b0, 1'b0, 5'd16);
    check_model("R1 reset state");
    // R10: en rises, word after one clock
    tick(); check_model("R10 idle before enable");
    en = 1'b1;
    tick(); check_word("R2 short first word / R10 latency", 16'hFF83);
    first = out_data;
    check_model("R2");
    for (int i = 1; i < 511; i++) begin tick(); check_model("R4 stream"); end
    tick(); check_word("R4 511-word repeat", first);
    check_model("R4");

    // R3 long sequence from seed
    do_reset(1'b1, 1'b0, 5'd16);
    en = 1'b1;
    tick(); check_word("R3 long first word", 16'hFFFF);
    tick(); check_word("R3 long second word", 16'hFE00);
    run(300, "R3 long stream");

    // R5 two's complement
    do_reset(1'b0, 1'b1, 5'd16);
    en = 1'b1;
    tick(); check_word("R5 twos first word", 16'h7F83);
    run(40, "R5 twos stream");
    fmt_sel = 1'b0; run(20, "R5 format switch");

    // R6 resolution explicit and sweep
    do_reset(1'b0, 1'b0, 5'd8);
    en = 1'b1;
    tick(); check_word("R6 res8 first", 16'hFF00);
    tick(); check_word("R6 res8 second", 16'h8300);
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 2; f++)
        for (int r = 8; r <= 16; r++) begin
          do_reset(m[0], f[0], 5'(r));
          en = 1'b1;
          run(30, "R6 R4 resolution sweep");
        end

    // R7 clamping
    do_reset(1'b0, 1'b0, 5'd3);
    en = 1'b1;
    tick(); check_word("R7 low clamp", 16'hFF00);
    run(20, "R7 low clamp stream");
    do_reset(1'b1, 1'b0, 5'd31);
    en = 1'b1;
    tick(); check_word("R7 high clamp", 16'hFFFF);
    tick(); check_word("R7 high clamp second", 16'hFE00);
    res_bits = 5'd20; run(20, "R7 high clamp stream");

    // R8 stall pattern
    do_reset(1'b0, 1'b0, 5'd12);
    en = 1'b1;
    run(5, "R8 pre-stall");
    held = out_data;
    en = 1'b0;
    tick();
    checks++;
    if (out_valid !== 1'b0 || out_data !== held) begin
      failures++;
      $display("FAIL R8 stall: data=%h valid=%b expected data=%h valid=0",
               out_data, out_valid, held);
    end
    for (int i = 0; i < 120; i++) begin
      en = (i % 3 != 0) && (i % 7 != 2);
      tick(); check_model("R8 enable pattern");
    end

    // R9 mode switching
    do_reset(1'b0, 1'b0, 5'd16);
    en = 1'b1;
    run(10, "R9 short run");
    mode_sel = 1'b1;
    tick(); check_word("R9 switch to long", 16'hFFFF);
    run(10, "R9 long run");
    mode_sel = 1'b0;
    tick(); check_word("R9 switch to short", 16'hFF83);
    run(10, "R9 short again");
    en = 1'b0; mode_sel = 1'b1;
    tick(); check_model("R9 switch while stalled");
    tick(); check_model("R9 stalled");
    en = 1'b1;
    tick(); check_word("R9 long after stalled switch", 16'hFFFF);
    tick(); check_word("R9 long second after stall", 16'hFE00);
    for (int i = 0; i < 60; i++) begin
      mode_sel = (i % 9) >= 5;
      en = (i % 4) != 3;
      tick(); check_model("R9 mixed switching");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule